// File: doc/BRIEF.md
# Add Bus Timing and Drive Controller

This block sits on the transmit side of a byte-wide add bus that carries an STM-1/STS-3c signal. The bus runs at one byte per clock at 19.44 MHz. Bit 7 of every byte is the first bit sent on the line. The block works out which byte slots it owns, drives the payload byte into those slots, and releases the bus on all other slots. On every slot it produces an active-low add indicator, an SPE flag, a composite C1/J1 marker and an odd parity bit.

The block has two timing sources.

- **Generated timing:** a free-running 9-row by 270-column counter produces the C1 marker, the J1 marker and the SPE flag. The counter repeats every 2430 clocks, which is one 125 µs frame. When `sep_c1_en` is set, the C1 marker is also copied onto a dedicated C1 output.
- **Bus timing:** the SPE flag and the markers come from the bus. A separate C1 input is ORed into the incoming marker line. A C1 marker seen outside SPE time realigns the internal counter, so a later change back to generated timing keeps the frame phase taken from the bus.

Payload bytes arrive on a plain input port. The column of the J1 byte inside the SPE is given as an offset.

Top module: `add_bus_ctrl`

## Requirements
- R1: In generated timing, a frame is 9 rows of 270 columns. Row 0, column 0 is frame position 0, the position counts up by one per clock, and the first clock after reset release is position 0. `c1j1_out` is high for exactly one clock at position 0 of every frame, so C1 pulses are 2430 clocks apart.
- R2: In generated timing, `spe_out` is high for columns 9 to 269 of every row and low for columns 0 to 8. `timing_oe` is 1 in generated timing and 0 in bus timing (`bus_timed`=1).
- R3: In generated timing with `poh_en`=1, `c1j1_out` also pulses for one clock at row 0, column 9+`j1_off`. A `j1_off` above 260 produces no J1 pulse. With `poh_en`=0 there is no J1 pulse.
- R4: `c1_out` is high together with the generated C1 pulse only when `sep_c1_en`=1. It stays low when `sep_c1_en`=0, and it is always low in bus timing.
- R5: In bus timing, `c1j1_out` equals `c1j1_in` OR `c1_in`, whatever the value of `sep_c1_en`. In generated timing, `c1j1_in` and `c1_in` have no effect on any output.
- R6: In bus timing, a composite marker that arrives while `spe_in`=0 marks frame position 0. The counter continues from that point. After a return to generated timing, the next C1 pulse therefore comes 2430 clocks after that marker, not at the old frame phase.
- R7: A slot is active when SPE is high: `spe_in` in bus timing, the generated flag otherwise. On an active slot, `ad_oe`=1, `add_n`=0 and `ad_out`=`pay_data`. On any other slot, `ad_oe`=0, `add_n`=1 and `ad_out`=0.
- R8: On an active slot, `par_out` makes the number of ones odd over the covered bits. The covered bits are `ad_out` plus `par_out`. In generated timing with `par_data_only`=0, `spe_out` and `c1j1_out` are covered as well. When `par_data_only`=1, or in bus timing, only the data byte is covered.
- R9: On a slot that is not active (unused overhead), `par_out` is 0.
- R10: While `rst_n` is low, the bus is not driven (`ad_oe`=0, `add_n`=1, `par_out`=0, `c1j1_out`=0), even if `spe_in` is high in bus timing. After release, the counter starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.44 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_timed | input | 1 | 1 = timing taken from the bus, 0 = timing generated internally |
| poh_en | input | 1 | Enables the generated J1 marker |
| sep_c1_en | input | 1 | Copies the generated C1 marker onto `c1_out` |
| par_data_only | input | 1 | Parity covers the data byte only |
| j1_off | input | 9 | J1 column offset from the first SPE column |
| pay_data | input | 8 | Payload byte for the current slot |
| c1j1_in | input | 1 | Incoming composite marker (bus timing) |
| c1_in | input | 1 | Incoming separate C1 marker (bus timing) |
| spe_in | input | 1 | Incoming SPE flag (bus timing) |
| ad_out | output | 8 | Data byte to the bus |
| ad_oe | output | 1 | Data bus drive enable |
| add_n | output | 1 | Active-low add indicator |
| c1j1_out | output | 1 | Composite C1/J1 marker |
| c1_out | output | 1 | Separate C1 marker |
| spe_out | output | 1 | SPE flag |
| timing_oe | output | 1 | Drive enable for the timing signals |
| par_out | output | 1 | Odd parity bit |

## Verification
The bench looks at the edges of the SPE window: columns 8 and 9, column 269, and the last slot of the frame. A counter that is off by one there would drive an overhead byte or drop a payload byte. It sets the J1 offset to the top of its range and turns path overhead off, which catches a marker placed in the wrong column or one that ignores the enable. Parity is checked with both coverage choices on bytes with odd and even numbers of ones, and on overhead slots, so a flipped sense, a wrong coverage set or parity left running on unused bytes shows up. Finally, one bus-timed marker moves the frame phase, and the bench checks that the next generated C1 follows the new phase and not the old one. Markers driven in during generated timing must leave that phase alone.

// File: rtl/add_bus_pkg.sv
package add_bus_pkg;

  // Timing source for the add bus.
  typedef enum logic {
    SRC_GEN = 1'b0,
    SRC_BUS = 1'b1
  } tsrc_e;

  // Next value of a wrapping counter with lim states.
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Parity bit that makes the total count of ones odd.
  function automatic logic odd_fill(input logic [15:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/add_bus_frame_ctr.sv
module add_bus_frame_ctr #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resync,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  import add_bus_pkg::*;

  logic last_col;
  logic last_row;

  assign last_col = (int'(col) == COLS - 1);
  assign last_row = (int'(row) == ROWS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (resync) begin
      // The resync clock is column 0, so the next clock is column 1.
      row <= '0;
      col <= CW'(1);
    end else begin
      col <= CW'(wrap_inc(int'(col), COLS));
      if (last_col) row <= RW'(wrap_inc(int'(row), ROWS));
    end
  end

  // R1: the frame wraps from the last slot back to position 0.
  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_col && last_row && !resync) |=> (row == '0 && col == '0));

  // R6: a resync pulse realigns the counter to row 0, column 1.
  a_r6_resync_load: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (row == '0 && col == CW'(1)));

endmodule

// File: rtl/add_bus_marker_gen.sv
module add_bus_marker_gen #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int TOH_COLS = 9,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic          bus_timed,
  input  logic          poh_en,
  input  logic          sep_c1_en,
  input  logic [CW-1:0] j1_off,
  input  logic          c1j1_in,
  input  logic          c1_in,
  input  logic          spe_in,
  output logic          comp_c1j1,
  output logic          c1_sep,
  output logic          spe_act,
  output logic          resync
);
  import add_bus_pkg::*;

  tsrc_e      src;
  logic       c1_slot;
  logic       j1_slot;
  logic       gen_spe;
  logic       bus_mark;
  logic [CW:0] j1_col;

  assign src      = tsrc_e'(bus_timed);
  assign c1_slot  = (row == '0) && (col == '0);
  assign j1_col   = (CW+1)'(TOH_COLS) + {1'b0, j1_off};
  assign j1_slot  = poh_en && (row == '0) && ({1'b0, col} == j1_col);
  assign gen_spe  = (col >= CW'(TOH_COLS));
  assign bus_mark = c1j1_in | c1_in;

  always_comb begin
    if (src == SRC_BUS) begin
      comp_c1j1 = bus_mark;
      spe_act   = spe_in;
      c1_sep    = 1'b0;
      resync    = bus_mark && !spe_in;
    end else begin
      comp_c1j1 = c1_slot | j1_slot;
      spe_act   = gen_spe;
      c1_sep    = sep_c1_en && c1_slot;
      resync    = 1'b0;
    end
  end

  // R3: a generated J1 marker always falls inside the SPE window.
  a_r3_j1_in_spe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_timed && j1_slot) |-> spe_act);

  // R4: the separate C1 marker never appears without the composite marker.
  a_r4_sep_in_comp: assert property (@(posedge clk) disable iff (!rst_n)
    c1_sep |-> comp_c1j1);

  // R1: the generated C1 slot lasts one clock.
  a_r1_c1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_timed && c1_slot) |=> !c1_slot);

endmodule

// File: rtl/add_bus_ctrl.sv
module add_bus_ctrl #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int TOH_COLS = 9,
  parameter int DW = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_timed,
  input  logic          poh_en,
  input  logic          sep_c1_en,
  input  logic          par_data_only,
  input  logic [CW-1:0] j1_off,
  input  logic [DW-1:0] pay_data,
  input  logic          c1j1_in,
  input  logic          c1_in,
  input  logic          spe_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          add_n,
  output logic          c1j1_out,
  output logic          c1_out,
  output logic          spe_out,
  output logic          timing_oe,
  output logic          par_out
);
  import add_bus_pkg::*;

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          resync;
  logic          comp_c1j1;
  logic          c1_sep;
  logic          spe_act;
  logic          slot_act;
  logic          full_cover;
  logic [DW+1:0] cover_bits;

  add_bus_frame_ctr #(.ROWS(ROWS), .COLS(COLS)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .resync (resync),
    .row    (row),
    .col    (col)
  );

  add_bus_marker_gen #(.ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS)) u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .row       (row),
    .col       (col),
    .bus_timed (bus_timed),
    .poh_en    (poh_en),
    .sep_c1_en (sep_c1_en),
    .j1_off    (j1_off),
    .c1j1_in   (c1j1_in),
    .c1_in     (c1_in),
    .spe_in    (spe_in),
    .comp_c1j1 (comp_c1j1),
    .c1_sep    (c1_sep),
    .spe_act   (spe_act),
    .resync    (resync)
  );

  // Nothing is driven while the block is held in reset.
  assign slot_act  = spe_act && rst_n;
  assign ad_oe     = slot_act;
  assign add_n     = !slot_act;
  assign ad_out    = slot_act ? pay_data : '0;
  assign spe_out   = spe_act && rst_n;
  assign c1j1_out  = comp_c1j1 && rst_n;
  assign c1_out    = c1_sep && rst_n;
  assign timing_oe = !bus_timed;

  // SPE and marker bits count toward parity only when this block drives them.
  assign full_cover = !bus_timed && !par_data_only;
  assign cover_bits = full_cover ? {ad_out, spe_out, c1j1_out} : {ad_out, 2'b00};
  assign par_out    = slot_act ? odd_fill(16'(cover_bits)) : 1'b0;

  // R9: parity is quiet on slots that are not driven.
  a_r9_par_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> !par_out);

  // R8: with data-only coverage, data plus parity has an odd number of ones.
  a_r8_odd_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && (bus_timed || par_data_only)) |-> (^{ad_out, par_out}));

  // R7: a released bus shows no data and no add indication.
  a_r7_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (add_n && ad_out == '0));

  // R4: the separate C1 output stays low in bus timing.
  a_r4_no_c1_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timed |-> !c1_out);

endmodule

// File: tb/add_bus_ctrl_bench.sv
`timescale 1ns/1ps
module add_bus_ctrl_bench;

  typedef struct packed {
    int         cyc;
    logic [7:0] d;
    logic       pardo;
    logic       sepc1;
    logic       act;
    logic       mark;
    logic       c1o;
  } vec_t;

  // Generated timing, poh_en=1, j1_off=5 (J1 in column 14).
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{0,    8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5,    8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8,    8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{9,    8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{14,   8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{15,   8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16,   8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{269,  8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{270,  8'h77, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{279,  8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2429, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2430, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_timed = 1'b0;
  logic       poh_en = 1'b1;
  logic       sep_c1_en = 1'b1;
  logic       par_data_only = 1'b0;
  logic [8:0] j1_off = 9'd5;
  logic [7:0] pay_data = 8'h00;
  logic       c1j1_in = 1'b0;
  logic       c1_in = 1'b0;
  logic       spe_in = 1'b0;
  logic [7:0] ad_out;
  logic       ad_oe, add_n, c1j1_out, c1_out, spe_out, timing_oe, par_out;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  add_bus_ctrl u_add_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_timed(bus_timed), .poh_en(poh_en),
    .sep_c1_en(sep_c1_en), .par_data_only(par_data_only), .j1_off(j1_off),
    .pay_data(pay_data), .c1j1_in(c1j1_in), .c1_in(c1_in), .spe_in(spe_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .add_n(add_n), .c1j1_out(c1j1_out),
    .c1_out(c1_out), .spe_out(spe_out), .timing_oe(timing_oe), .par_out(par_out)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
    end
  endtask

  // Odd parity worked out from a count of ones.
  function automatic logic exp_par(input logic [7:0] d, input logic act,
                                   input logic full, input logic mark);
    int n = 0;
    if (!act) return 1'b0;
    for (int i = 0; i < 8; i++) n += int'(d[i]);
    if (full) n += 1 + int'(mark);
    return (n % 2) == 0;
  endfunction

  // Step to a frame position: one falling edge per clock, then settle.
  task automatic adv_to(input int target);
    while (cyc < target) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    // R10: held in reset, even with spe_in high in bus timing.
    bus_timed = 1'b1;
    spe_in = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 ad_oe in reset", {7'd0, ad_oe}, 8'd0);
    chk("R10 add_n in reset", {7'd0, add_n}, 8'd1);
    chk("R10 par in reset", {7'd0, par_out}, 8'd0);
    bus_timed = 1'b0;
    spe_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;

    // Table walk: R1 R2 R3 R4 R7 R8 R9.
    for (int v = 0; v < NV; v++) begin
      adv_to(VEC[v].cyc);
      pay_data = VEC[v].d;
      par_data_only = VEC[v].pardo;
      sep_c1_en = VEC[v].sepc1;
      #1;
      chk("R7 ad_oe", {7'd0, ad_oe}, {7'd0, VEC[v].act});
      chk("R7 add_n", {7'd0, add_n}, {7'd0, !VEC[v].act});
      chk("R7 ad_out", ad_out, VEC[v].act ? VEC[v].d : 8'h00);
      chk("R2 spe_out", {7'd0, spe_out}, {7'd0, VEC[v].act});
      chk("R2 timing_oe", {7'd0, timing_oe}, 8'd1);
      chk("R1/R3 c1j1_out", {7'd0, c1j1_out}, {7'd0, VEC[v].mark});
      chk("R4 c1_out", {7'd0, c1_out}, {7'd0, VEC[v].c1o});
      chk("R8/R9 par_out", {7'd0, par_out},
          {7'd0, exp_par(VEC[v].d, VEC[v].act, !VEC[v].pardo, VEC[v].mark)});
    end

    // R3: largest J1 offset puts J1 in column 269.
    j1_off = 9'd260;
    adv_to(2698);
    #1 chk("R3 no J1 at col 268", {7'd0, c1j1_out}, 8'd0);
    adv_to(2699);
    #1 chk("R3 J1 at col 269", {7'd0, c1j1_out}, 8'd1);
    j1_off = 9'd5;

    // R4: C1 with the separate lead turned off.
    adv_to(4860);
    sep_c1_en = 1'b0;
    #1;
    chk("R4 c1_out off", {7'd0, c1_out}, 8'd0);
    chk("R1 c1j1 frame 3", {7'd0, c1j1_out}, 8'd1);

    // R3: path overhead off, no J1.
    poh_en = 1'b0;
    adv_to(4874);
    #1 chk("R3 no J1 when poh off", {7'd0, c1j1_out}, 8'd0);
    poh_en = 1'b1;

    // R5: bus markers in generated timing have no effect.
    adv_to(4880);
    c1j1_in = 1'b1;
    c1_in = 1'b1;
    #1 chk("R5 inputs ignored", {7'd0, c1j1_out}, 8'd0);
    adv_to(4881);
    c1j1_in = 1'b0;
    c1_in = 1'b0;
    adv_to(7289);
    #1 chk("R5 phase kept (before)", {7'd0, c1j1_out}, 8'd0);
    adv_to(7290);
    #1 chk("R5 phase kept (C1)", {7'd0, c1j1_out}, 8'd1);

    // Bus timing.
    adv_to(7300);
    bus_timed = 1'b1;
    spe_in = 1'b0;
    pay_data = 8'hC3;
    #1;
    chk("R2 timing_oe bus", {7'd0, timing_oe}, 8'd0);
    chk("R7 idle in bus timing", {7'd0, ad_oe}, 8'd0);
    adv_to(7310);
    c1_in = 1'b1;
    #1;
    chk("R5 c1_in ORed", {7'd0, c1j1_out}, 8'd1);
    chk("R4 c1_out bus", {7'd0, c1_out}, 8'd0);
    adv_to(7311);
    c1_in = 1'b0;
    c1j1_in = 1'b1;
    spe_in = 1'b1;
    pay_data = 8'h00;
    #1;
    chk("R5 c1j1_in passes", {7'd0, c1j1_out}, 8'd1);
    chk("R7 bus active", {7'd0, add_n}, 8'd0);
    chk("R8 bus data-only parity", {7'd0, par_out}, 8'd1);
    adv_to(7312);
    c1j1_in = 1'b0;
    pay_data = 8'hFF;
    #1;
    chk("R7 bus data", ad_out, 8'hFF);
    chk("R8 bus parity FF", {7'd0, par_out}, 8'd1);
    adv_to(7313);
    spe_in = 1'b0;
    #1;
    chk("R9 parity off", {7'd0, par_out}, 8'd0);
    chk("R7 released", {7'd0, ad_oe}, 8'd0);
    adv_to(7314);
    bus_timed = 1'b0;

    // R6: new phase from the marker at 7310.
    adv_to(9720);
    #1 chk("R6 old phase gone", {7'd0, c1j1_out}, 8'd0);
    adv_to(9739);
    #1 chk("R6 before new C1", {7'd0, c1j1_out}, 8'd0);
    adv_to(9740);
    #1 chk("R6 new C1", {7'd0, c1j1_out}, 8'd1);

    // R10: reset mid-frame, then restart at position 0.
    adv_to(9800);
    rst_n = 1'b0;
    #1;
    chk("R10 ad_oe held", {7'd0, ad_oe}, 8'd0);
    chk("R10 c1j1 held", {7'd0, c1j1_out}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    #1;
    chk("R10 restart C1", {7'd0, c1j1_out}, 8'd1);
    adv_to(9);
    #1 chk("R10 restart SPE", {7'd0, spe_out}, 8'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule